// File: doc/BRIEF.md
# Serial Port Interrupt Flag and Mask Unit

This unit keeps the three event flags of a byte-oriented serial port and turns them into interrupt requests. The flags are transmit buffer empty, receive buffer full and receive error. The transmit and receive datapaths pulse a set input when an event happens. Each flag is then cleared as a side effect of the register access that services it: writing the transmit buffer, reading the receive buffer, or reading the status register. No separate acknowledge register exists.

A three-bit interrupt-enable register masks each request on its own. Clearing an enable bit withdraws its request, but the flag underneath stays as it was. The three individual requests are combinational from the registered flags and enables. A combined request is registered one cycle behind them. If a datapath set pulse and a clearing access arrive in the same cycle, the set wins, so no event is lost.

Top module: `usart_irq_ctrl`

## Requirements
- R1: After reset, `tx_empty_o` is 1, `rx_full_o` and `err_flag_o` are 0, all enables are 0, and every interrupt output is 0.
- R2: A cycle with `ien_wr_i` high loads `ien_wdata_i` into the enable register, and the new value acts from the next cycle. Bit 0 enables transmit, bit 1 enables receive and bit 2 enables error. Without a write, the enables hold.
- R3: `irq_tx_o` is 1 exactly when the transmit-empty flag and enable bit 0 are both 1. `tx_load_i` sets the flag and `tbuf_wr_i` clears it, each at the next clock edge.
- R4: `irq_rx_o` is 1 exactly when the receive-full flag and enable bit 1 are both 1. `rx_done_i` sets the flag and `rbuf_rd_i` clears it, each at the next clock edge.
- R5: `irq_err_o` is 1 exactly when the error flag and enable bit 2 are both 1. `rx_fault_i` sets the flag and `stat_rd_i` clears it, each at the next clock edge.
- R6: Clearing an enable bit removes its request from the next cycle and leaves the flag value unchanged.
- R7: When a set pulse and the matching clearing access occur in the same cycle, the flag is 1 after the edge.
- R8: A flag changes only through its own set pulse or its own clearing access. Strobes that belong to other sources have no effect on it.
- R9: `irq_any_o` equals the OR of the three individual requests of the previous cycle. It is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load_i | input | 1 | Transmit datapath took the buffer; sets transmit-empty flag |
| rx_done_i | input | 1 | Receive datapath filled the buffer; sets receive-full flag |
| rx_fault_i | input | 1 | Receive datapath saw a frame error; sets error flag |
| tbuf_wr_i | input | 1 | Transmit buffer write strobe; clears transmit-empty |
| rbuf_rd_i | input | 1 | Receive buffer read strobe; clears receive-full |
| stat_rd_i | input | 1 | Status register read strobe; clears error flag |
| ien_wr_i | input | 1 | Enable register write strobe |
| ien_wdata_i | input | 3 | Enable write data: bit0 tx, bit1 rx, bit2 error |
| tx_empty_o | output | 1 | Transmit-empty flag |
| rx_full_o | output | 1 | Receive-full flag |
| err_flag_o | output | 1 | Receive error flag |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_err_o | output | 1 | Error interrupt request |
| irq_any_o | output | 1 | Registered OR of the three requests |

## Verification
The bench aims at a set pulse and its clearing access landing in one cycle. A design that let the clear win would drop that event, so the flag would read 0 and the request would vanish. It also masks a pending source and then unmasks it. A design that cleared the flag along with the mask would not raise the request again. Random cycles mix strobes across all three sources to catch a strobe wired to the wrong flag. Every cycle, the bench compares the combined line with the previous cycle's requests, which exposes a combined output that is unregistered or delayed by two cycles.

// File: rtl/usart_irq_pkg.sv
package usart_irq_pkg;
    localparam int NUM_SRC = 3;
    localparam int IDX_TX  = 0;
    localparam int IDX_RX  = 1;
    localparam int IDX_ERR = 2;
    // reset value of each flag: transmit-empty starts set
    localparam logic [NUM_SRC-1:0] FLAG_RST = 3'b001;
endpackage

// File: rtl/usart_irq_flag.sv
module usart_irq_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;          // set has priority
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R7: a set in the same cycle as a clear still leaves the flag high
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R3 R4 R5: a lone clearing access drops the flag
    a_r5_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R8: no strobe, no change
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/usart_irq_mask.sv
module usart_irq_mask #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    // R2: a write lands on the next edge
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(wdata_i)));
    // R2: without a write the enables hold
    a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/usart_irq_ctrl.sv
module usart_irq_ctrl
    import usart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_load_i,
    input  logic       rx_done_i,
    input  logic       rx_fault_i,
    input  logic       tbuf_wr_i,
    input  logic       rbuf_rd_i,
    input  logic       stat_rd_i,
    input  logic       ien_wr_i,
    input  logic [2:0] ien_wdata_i,
    output logic       tx_empty_o,
    output logic       rx_full_o,
    output logic       err_flag_o,
    output logic       irq_tx_o,
    output logic       irq_rx_o,
    output logic       irq_err_o,
    output logic       irq_any_o
);
    typedef struct packed {
        logic any;
    } top_st_t;

    logic [NUM_SRC-1:0] set_vec, clr_vec, flag_vec, en_vec, irq_vec;
    top_st_t st_d, st_q;

    assign set_vec[IDX_TX]  = tx_load_i;
    assign set_vec[IDX_RX]  = rx_done_i;
    assign set_vec[IDX_ERR] = rx_fault_i;
    assign clr_vec[IDX_TX]  = tbuf_wr_i;
    assign clr_vec[IDX_RX]  = rbuf_rd_i;
    assign clr_vec[IDX_ERR] = stat_rd_i;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        usart_irq_flag #(
            .RST_VAL (FLAG_RST[i])
        ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_vec[i])
        );
    end

    usart_irq_mask #(
        .W (NUM_SRC)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ien_wr_i),
        .wdata_i (ien_wdata_i),
        .en_o    (en_vec)
    );

    assign irq_vec = flag_vec & en_vec;

    always_comb begin
        st_d     = st_q;
        st_d.any = |irq_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.any <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_empty_o = flag_vec[IDX_TX];
    assign rx_full_o  = flag_vec[IDX_RX];
    assign err_flag_o = flag_vec[IDX_ERR];
    assign irq_tx_o   = irq_vec[IDX_TX];
    assign irq_rx_o   = irq_vec[IDX_RX];
    assign irq_err_o  = irq_vec[IDX_ERR];
    assign irq_any_o  = st_q.any;

    // R9: combined line follows the requests one cycle later
    a_r9_any_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_any_o == $past(irq_tx_o | irq_rx_o | irq_err_o)));
    // R6: masking transmit drops its request and keeps its flag
    a_r6_mask_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr_i && !ien_wdata_i[0] && !tx_load_i && !tbuf_wr_i)
        |=> (!irq_tx_o && $stable(tx_empty_o)));
    // R4: receive request needs both flag and enable after a set with bit 1 written
    a_r4_rx_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && ien_wr_i && ien_wdata_i[1]) |=> irq_rx_o);
endmodule

// File: tb/tb_usart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_usart_irq_ctrl;
    localparam real CYC = 8.0;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_load, rx_done, rx_fault, tbuf_wr, rbuf_rd, stat_rd, ien_wr;
    logic [2:0] ien_wdata;
    logic       tx_empty, rx_full, err_flag, irq_tx, irq_rx, irq_err, irq_any;

    int n_chk = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    // bench model
    logic [2:0] m_flag, m_en;
    logic       m_any;

    always #(CYC/2.0) clk = ~clk;

    usart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .tx_load_i(tx_load), .rx_done_i(rx_done), .rx_fault_i(rx_fault),
        .tbuf_wr_i(tbuf_wr), .rbuf_rd_i(rbuf_rd), .stat_rd_i(stat_rd),
        .ien_wr_i(ien_wr), .ien_wdata_i(ien_wdata),
        .tx_empty_o(tx_empty), .rx_full_o(rx_full), .err_flag_o(err_flag),
        .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err),
        .irq_any_o(irq_any)
    );

    function automatic logic f_next(input logic q, input logic s, input logic c);
        return s | (q & ~c);
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "tx_empty", tx_empty, m_flag[0]);
        chk(tag, "rx_full",  rx_full,  m_flag[1]);
        chk(tag, "err_flag", err_flag, m_flag[2]);
        chk(tag, "irq_tx R3",  irq_tx,  m_flag[0] & m_en[0]);
        chk(tag, "irq_rx R4",  irq_rx,  m_flag[1] & m_en[1]);
        chk(tag, "irq_err R5", irq_err, m_flag[2] & m_en[2]);
        chk(tag, "irq_any R9", irq_any, m_any);
    endtask

    // drive at negedge, clock once, update model, check at next negedge
    task automatic step(input string tag, input logic [2:0] s, input logic [2:0] c,
                        input logic w, input logic [2:0] wd);
        logic [2:0] nf, ne;
        logic       na;
        {rx_fault, rx_done, tx_load} = s;
        {stat_rd, rbuf_rd, tbuf_wr}  = c;
        ien_wr = w;
        ien_wdata = wd;
        for (int i = 0; i < 3; i++) nf[i] = f_next(m_flag[i], s[i], c[i]);
        ne = w ? wd : m_en;
        na = |(m_flag & m_en);
        @(posedge clk);
        m_flag = nf;
        m_en = ne;
        m_any = na;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CYC * 200000.0);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        {tx_load, rx_done, rx_fault, tbuf_wr, rbuf_rd, stat_rd, ien_wr} = '0;
        ien_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_flag = 3'b001; m_en = 3'b000; m_any = 1'b0;
        check_all("R1");

        // R2: enable transmit only; tx flag already set
        step("R2", 3'b000, 3'b000, 1'b1, 3'b001);
        step("R9", 3'b000, 3'b000, 1'b0, 3'b000);
        // R3: buffer write clears transmit-empty
        step("R3", 3'b000, 3'b001, 1'b0, 3'b000);
        // R2: enable all
        step("R2", 3'b000, 3'b000, 1'b1, 3'b111);
        // R4: receive set then read
        step("R4", 3'b010, 3'b000, 1'b0, 3'b000);
        step("R4", 3'b000, 3'b010, 1'b0, 3'b000);
        // R5: error set then status read
        step("R5", 3'b100, 3'b000, 1'b0, 3'b000);
        // R8: foreign strobes do not touch the error flag
        step("R8", 3'b000, 3'b011, 1'b0, 3'b000);
        step("R5", 3'b000, 3'b100, 1'b0, 3'b000);
        // R7: set and clear together on every source
        step("R7", 3'b111, 3'b111, 1'b0, 3'b000);
        // R6: mask all, flags stay, then unmask brings requests back
        step("R6", 3'b000, 3'b000, 1'b1, 3'b000);
        step("R6", 3'b000, 3'b000, 1'b0, 3'b000);
        step("R6", 3'b000, 3'b000, 1'b1, 3'b101);
        // R8: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] s, c, wd;
            logic w;
            s  = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            c  = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            w  = ($urandom_range(0, 7) == 0);
            wd = 3'($urandom_range(0, 7));
            step("R8", s, c, w, wd);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule